// File: doc/BRIEF.md
# Bank-Interleaved Dual Free List

This block hands out and takes back fixed-size segment indices for a banked DRAM buffer. Free segments are kept on two linked lists that share one internal next-pointer array. Each list holds alternating runs of four consecutive segments: list A holds the runs whose index bit 2 is 0, and list B holds the runs whose index bit 2 is 1. Successive grants are taken alternately from the two lists, so back-to-back buffer writes fall into different bank groups, while consecutive segments within a run stay on the same DRAM page.

A release returns a whole chain of segments in one cycle. The chain is given by its head index, tail index and segment count. It is spliced onto the front of one list with a single pointer write, so the cost does not depend on how long the chain is. Queue logic links the segments of a chain while it holds them, through a link-write port into the same next-pointer array.

The controller has two states. In INIT, which is entered on reset, a walker writes one next-pointer entry per cycle in ascending index order. When the last entry has been written, the transition INIT to RUN is taken. In RUN, grants, releases and link writes are served. The block leaves RUN only through reset.

Top module: `seg_dual_freelist`

## Requirements
- R1: While reset is asserted and for the first 2^SEG_W cycles after reset is released (state INIT), alloc_gnt is low and free_cnt0 and free_cnt1 each equal 2^SEG_W/2. From the next cycle on, alloc_gnt is high.
- R2: After initialisation, segment i is on list A (counter free_cnt0) when bit RUN_LG (bit 2 by default) of i is 0, and on list B (free_cnt1) when that bit is 1.
- R3: After initialisation, each list serves its segments in ascending order: list A serves 0,1,2,3,8,9,… and list B serves 4,5,6,7,12,….
- R4: The first grant after initialisation comes from list A. After every grant, the other list becomes the preferred list. alloc_idx shows the head of the list that would be served.
- R5: If the preferred list is empty and the other list is not, the other list serves the grant.
- R6: When both lists are empty, alloc_gnt is low, and a request changes neither the counters nor the next grant.
- R7: A grant lowers the counter of the list that served it by one. A release raises the counter of the list chosen by bit RUN_LG of rel_head by rel_cnt.
- R8: A release and a grant in the same cycle both take effect, whether they act on the same list or on different lists. The grant returns the head that list had before the release.
- R9: Releases and link writes presented during INIT are ignored.
- R10: empty0 is high exactly when free_cnt0 is zero, and empty1 is high exactly when free_cnt1 is zero.
- R11: After a release, the chosen list serves rel_head first, then the segments that follow it through the links written with link_we, then what the list held before. If a link write and a release's tail write target the same entry, the release's tail write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts INIT |
| alloc_req | input | 1 | Request one segment |
| alloc_gnt | output | 1 | A segment is available; a grant happens when alloc_req is also high |
| alloc_idx | output | SEG_W | Index of the segment that would be granted |
| rel_valid | input | 1 | Release a chain this cycle |
| rel_head | input | SEG_W | First segment of the released chain; its bit RUN_LG selects the list |
| rel_tail | input | SEG_W | Last segment of the released chain |
| rel_cnt | input | SEG_W+1 | Number of segments in the chain |
| link_we | input | 1 | Write one next-pointer entry of a held segment |
| link_addr | input | SEG_W | Segment whose next pointer is written |
| link_data | input | SEG_W | New next-pointer value |
| free_cnt0 | output | SEG_W+1 | Free segments on list A |
| free_cnt1 | output | SEG_W+1 | Free segments on list B |
| empty0 | output | 1 | List A is empty |
| empty1 | output | 1 | List B is empty |

## Verification
The in-RTL assertions check the following on every cycle:
- the counters stay at their initial values throughout INIT;
- a grant with no release lowers the total free count by exactly one;
- a release with no grant raises the total by rel_cnt;
- two grants in a row come from opposite lists whenever both lists held segments;
- no grant is offered when both lists are empty.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle against a queue-based model:
- the ascending run order after initialisation;
- the order in which a spliced chain is served;
- the fallback to the other list once one list drains;
- the results of a release and a grant in the same cycle.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
    // Controller phase: INIT walks the pointer array, RUN serves traffic.
    typedef enum logic [0:0] {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } sdf_state_e;
endpackage

// File: rtl/sdf_init_walker.sv
`timescale 1ns/1ps
// Writes the initial next-pointer of one segment per cycle. Inside a run
// the link goes to i+1; the last segment of a run skips over the other
// list's run and links to i+RUN+1.
module sdf_init_walker #(
    parameter int SEG_W  = 6,
    parameter int RUN_LG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic             wr_en,
    output logic [SEG_W-1:0] wr_addr,
    output logic [SEG_W-1:0] wr_data,
    output logic             last
);
    localparam int RUN = 1 << RUN_LG;
    localparam logic [SEG_W-1:0] RUN_MASK  = SEG_W'(RUN - 1);
    localparam logic [SEG_W-1:0] STEP_IN   = SEG_W'(1);
    localparam logic [SEG_W-1:0] STEP_SKIP = SEG_W'(RUN + 1);

    logic [SEG_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (en) begin
            idx_q <= idx_q + STEP_IN;
        end
    end

    always_comb begin
        wr_en   = en;
        wr_addr = idx_q;
        if ((idx_q & RUN_MASK) == RUN_MASK) begin
            wr_data = idx_q + STEP_SKIP;
        end else begin
            wr_data = idx_q + STEP_IN;
        end
        last = en && (idx_q == '1);
    end
endmodule

// File: rtl/sdf_link_mem.sv
`timescale 1ns/1ps
// Shared next-pointer array: two write ports (A has priority on the same
// address) and one combinational read port.
module sdf_link_mem #(
    parameter int SEG_W = 6
) (
    input  logic             clk,
    input  logic             pa_we,
    input  logic [SEG_W-1:0] pa_addr,
    input  logic [SEG_W-1:0] pa_data,
    input  logic             pb_we,
    input  logic [SEG_W-1:0] pb_addr,
    input  logic [SEG_W-1:0] pb_data,
    input  logic [SEG_W-1:0] rd_addr,
    output logic [SEG_W-1:0] rd_data
);
    localparam int DEPTH = 1 << SEG_W;

    logic [SEG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (pb_we && !(pa_we && (pa_addr == pb_addr))) begin
            mem[pb_addr] <= pb_data;
        end
        if (pa_we) begin
            mem[pa_addr] <= pa_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sdf_pick.sv
`timescale 1ns/1ps
// Chooses the list that serves the next grant: the preferred list when it
// holds segments, otherwise the other one.
module sdf_pick #(
    parameter int CNT_W = 7
) (
    input  logic             run,
    input  logic             pref,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             avail,
    output logic             sel
);
    logic has_a;
    logic has_b;
    logic pref_has;

    always_comb begin
        has_a    = (cnt_a != '0);
        has_b    = (cnt_b != '0);
        pref_has = pref ? has_b : has_a;
        sel      = pref_has ? pref : ~pref;
        avail    = run && (has_a || has_b);
    end
endmodule

// File: rtl/seg_dual_freelist.sv
`timescale 1ns/1ps
module seg_dual_freelist
    import sdf_pkg::*;
#(
    parameter int SEG_W  = 6,
    parameter int RUN_LG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    output logic               alloc_gnt,
    output logic [SEG_W-1:0]   alloc_idx,
    input  logic               rel_valid,
    input  logic [SEG_W-1:0]   rel_head,
    input  logic [SEG_W-1:0]   rel_tail,
    input  logic [SEG_W:0]     rel_cnt,
    input  logic               link_we,
    input  logic [SEG_W-1:0]   link_addr,
    input  logic [SEG_W-1:0]   link_data,
    output logic [SEG_W:0]     free_cnt0,
    output logic [SEG_W:0]     free_cnt1,
    output logic               empty0,
    output logic               empty1
);
    localparam int NSEG  = 1 << SEG_W;
    localparam int RUN   = 1 << RUN_LG;
    localparam int CNT_W = SEG_W + 1;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(NSEG / 2);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    sdf_state_e st_q, st_d;
    logic walk_en, run_mode;

    logic             init_we, init_last;
    logic [SEG_W-1:0] init_addr, init_data;

    logic [SEG_W-1:0] head_q [2];
    logic [SEG_W-1:0] head_d [2];
    logic [CNT_W-1:0] cnt_q  [2];
    logic [CNT_W-1:0] cnt_d  [2];
    logic             pref_q, pref_d;

    logic             avail, sel, alloc_fire, rel_fire, rel_list;
    logic [SEG_W-1:0] nxt_of_head, splice_ptr;
    logic             pa_we, pb_we;
    logic [SEG_W-1:0] pa_addr, pa_data;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT: if (init_last) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        unique case (st_q)
            ST_INIT: begin
                walk_en  = 1'b1;
                run_mode = 1'b0;
            end
            ST_RUN: begin
                walk_en  = 1'b0;
                run_mode = 1'b1;
            end
        endcase
    end

    sdf_init_walker #(.SEG_W(SEG_W), .RUN_LG(RUN_LG)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (walk_en),
        .wr_en   (init_we),
        .wr_addr (init_addr),
        .wr_data (init_data),
        .last    (init_last)
    );

    sdf_pick #(.CNT_W(CNT_W)) u_pick (
        .run   (run_mode),
        .pref  (pref_q),
        .cnt_a (cnt_q[0]),
        .cnt_b (cnt_q[1]),
        .avail (avail),
        .sel   (sel)
    );

    sdf_link_mem #(.SEG_W(SEG_W)) u_links (
        .clk     (clk),
        .pa_we   (pa_we),
        .pa_addr (pa_addr),
        .pa_data (pa_data),
        .pb_we   (pb_we),
        .pb_addr (link_addr),
        .pb_data (link_data),
        .rd_addr (head_q[sel]),
        .rd_data (nxt_of_head)
    );

    // ---------------- grant / release datapath ----------------
    always_comb begin
        alloc_gnt  = avail;
        alloc_idx  = head_q[sel];
        alloc_fire = alloc_req && avail;
        rel_fire   = rel_valid && run_mode;
        rel_list   = rel_head[RUN_LG];
        // Same-list grant and splice: the chain's tail takes over the link
        // of the segment being granted.
        if (alloc_fire && (sel == rel_list)) begin
            splice_ptr = nxt_of_head;
        end else begin
            splice_ptr = head_q[rel_list];
        end
        pa_we   = init_we || rel_fire;
        pa_addr = walk_en ? init_addr : rel_tail;
        pa_data = walk_en ? init_data : splice_ptr;
        pb_we   = link_we && run_mode;
        pref_d  = alloc_fire ? ~sel : pref_q;
    end

    always_comb begin
        logic pop_l;
        logic push_l;
        for (int l = 0; l < 2; l++) begin
            pop_l  = alloc_fire && (sel == 1'(l));
            push_l = rel_fire && (rel_list == 1'(l));
            if (push_l) begin
                head_d[l] = rel_head;
            end else if (pop_l) begin
                head_d[l] = nxt_of_head;
            end else begin
                head_d[l] = head_q[l];
            end
            cnt_d[l] = cnt_q[l] + (push_l ? rel_cnt : '0) - (pop_l ? ONE : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin
                head_q[l] <= SEG_W'(l * RUN);
                cnt_q[l]  <= HALF;
            end
            pref_q <= 1'b0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                head_q[l] <= head_d[l];
                cnt_q[l]  <= cnt_d[l];
            end
            pref_q <= pref_d;
        end
    end

    assign free_cnt0 = cnt_q[0];
    assign free_cnt1 = cnt_q[1];
    assign empty0    = (cnt_q[0] == '0);
    assign empty1    = (cnt_q[1] == '0);

    // ---------------- assertions ----------------
    // R1: counters hold their initial split and no grant is offered in INIT.
    a_r1_init_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_INIT) |-> (free_cnt0 == HALF && free_cnt1 == HALF && !alloc_gnt));

    // R4: two grants in a row come from opposite lists while both lists hold segments.
    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && cnt_q[0] != '0 && cnt_q[1] != '0) |=> (!alloc_fire || (sel != $past(sel))));

    // R6: no grant is offered when both lists are empty.
    a_r6_empty_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt0 == '0 && free_cnt1 == '0) |-> !alloc_gnt);

    // R7: a lone grant removes exactly one free segment.
    a_r7_grant_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !rel_fire) |=>
        ((free_cnt0 + free_cnt1) == ($past(free_cnt0) + $past(free_cnt1) - ONE)));

    // R7: a lone release adds its chain length.
    a_r7_release_add: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_fire && !alloc_fire) |=>
        ((free_cnt0 + free_cnt1) == ($past(free_cnt0) + $past(free_cnt1) + $past(rel_cnt))));
endmodule

// File: tb/seg_dual_freelist_tb.sv
`timescale 1ns/1ps
module seg_dual_freelist_tb;
    localparam int SEG_W  = 6;
    localparam int RUN_LG = 2;
    localparam int NSEG   = 1 << SEG_W;
    localparam int HALF   = NSEG / 2;
    localparam int CNT_W  = SEG_W + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             alloc_req = 1'b0;
    logic             alloc_gnt;
    logic [SEG_W-1:0] alloc_idx;
    logic             rel_valid = 1'b0;
    logic [SEG_W-1:0] rel_head = '0;
    logic [SEG_W-1:0] rel_tail = '0;
    logic [CNT_W-1:0] rel_cnt = '0;
    logic             link_we = 1'b0;
    logic [SEG_W-1:0] link_addr = '0;
    logic [SEG_W-1:0] link_data = '0;
    logic [CNT_W-1:0] free_cnt0, free_cnt1;
    logic             empty0, empty1;

    seg_dual_freelist #(.SEG_W(SEG_W), .RUN_LG(RUN_LG)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
        .rel_valid(rel_valid), .rel_head(rel_head), .rel_tail(rel_tail), .rel_cnt(rel_cnt),
        .link_we(link_we), .link_addr(link_addr), .link_data(link_data),
        .free_cnt0(free_cnt0), .free_cnt1(free_cnt1), .empty0(empty0), .empty1(empty1)
    );

    int n_run = 0;
    int n_fail = 0;
    int n_fallback = 0;

    // behavioural model: two queues of free segments plus a preference bit
    int qa[$];
    int qb[$];
    int init_left;
    bit pref;

    bit drv_req, drv_rel, drv_lw;
    int drv_la, drv_ld;
    int chain[$];
    int got[$];
    int exp_s[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lsize(input bit l);
        return l ? qb.size() : qa.size();
    endfunction

    // Compare at the current negedge, drive inputs, advance the model, wait a cycle.
    task automatic step();
        bit exp_gnt, exp_sel, fire;
        int exp_idx, rl;
        exp_gnt = (init_left == 0) && ((qa.size() + qb.size()) > 0);
        chk(alloc_gnt === exp_gnt, (init_left > 0) ? "R1 grant held in init" : "R6 grant availability",
            int'(alloc_gnt), int'(exp_gnt));
        exp_sel = (lsize(pref) > 0) ? pref : ~pref;
        exp_idx = 0;
        if (exp_gnt) begin
            exp_idx = exp_sel ? qb[0] : qa[0];
            chk(int'(alloc_idx) == exp_idx, "R4 offered index", int'(alloc_idx), exp_idx);
        end
        chk(int'(free_cnt0) == qa.size(), "R7 list A count", int'(free_cnt0), qa.size());
        chk(int'(free_cnt1) == qb.size(), "R7 list B count", int'(free_cnt1), qb.size());
        chk(empty0 === (qa.size() == 0), "R10 list A empty flag", int'(empty0), int'(qa.size() == 0));
        chk(empty1 === (qb.size() == 0), "R10 list B empty flag", int'(empty1), int'(qb.size() == 0));

        alloc_req = drv_req;
        rel_valid = drv_rel;
        if (chain.size() > 0) begin
            rel_head = SEG_W'(chain[0]);
            rel_tail = SEG_W'(chain[chain.size()-1]);
            rel_cnt  = CNT_W'(chain.size());
        end
        link_we   = drv_lw;
        link_addr = SEG_W'(drv_la);
        link_data = SEG_W'(drv_ld);

        if (init_left > 0) begin
            init_left--;
        end else begin
            fire = drv_req && exp_gnt;
            if (fire) begin
                if (lsize(pref) == 0) begin
                    n_fallback++;
                    chk(int'(alloc_idx) == exp_idx, "R5 fallback list serves", int'(alloc_idx), exp_idx);
                end
                if (drv_rel) begin
                    chk(int'(alloc_idx) == exp_idx, "R8 grant beside release", int'(alloc_idx), exp_idx);
                end
                if (exp_sel) void'(qb.pop_front());
                else         void'(qa.pop_front());
                pref = ~exp_sel;
                got.push_back(int'(alloc_idx));
            end
            if (drv_rel) begin
                rl = (chain[0] >> RUN_LG) & 1;
                for (int i = chain.size() - 1; i >= 0; i--) begin
                    if (rl != 0) qb.push_front(chain[i]);
                    else         qa.push_front(chain[i]);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        drv_req = 0; drv_rel = 0; drv_lw = 0;
        repeat (n) step();
    endtask

    task automatic grab(input int n);
        drv_req = 1; drv_rel = 0; drv_lw = 0;
        repeat (n) step();
        drv_req = 0;
    endtask

    task automatic link(input int a, input int d);
        drv_req = 0; drv_rel = 0; drv_lw = 1; drv_la = a; drv_ld = d;
        step();
        drv_lw = 0;
    endtask

    task automatic seq_check(input string tag);
        chk(got.size() == exp_s.size(), tag, got.size(), exp_s.size());
        for (int i = 0; i < exp_s.size(); i++) begin
            if (i < got.size()) chk(got[i] == exp_s[i], tag, got[i], exp_s[i]);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            if (((i >> RUN_LG) & 1) != 0) qb.push_back(i);
            else                          qa.push_back(i);
        end
        pref = 0;
        init_left = NSEG;
        drv_req = 0; drv_rel = 0; drv_lw = 0; drv_la = 0; drv_ld = 0;

        // R1: reset values
        repeat (3) begin
            @(negedge clk);
            chk(alloc_gnt === 1'b0, "R1 no grant in reset", int'(alloc_gnt), 0);
            chk(int'(free_cnt0) == HALF && int'(free_cnt1) == HALF, "R1 reset counts",
                int'(free_cnt0), HALF);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R9: releases during INIT are ignored
        chain = '{9, 10};
        drv_rel = 1;
        repeat (5) step();
        drv_rel = 0;
        idle(NSEG - 5);
        chk(int'(free_cnt0) == HALF, "R9 list A untouched by init release", int'(free_cnt0), HALF);
        chk(int'(free_cnt1) == HALF, "R9 list B untouched by init release", int'(free_cnt1), HALF);
        chk(alloc_gnt === 1'b1, "R1 ready after init", int'(alloc_gnt), 1);

        // R2 R3 R4: fresh lists, alternating ascending runs
        got.delete();
        grab(8);
        exp_s = '{0, 4, 1, 5, 2, 6, 3, 7};
        seq_check("R3 initial run order");
        for (int i = 0; i < 8; i++) begin
            if (i < got.size())
                chk(((got[i] >> RUN_LG) & 1) == (i % 2), "R2 list by index bit", (got[i] >> RUN_LG) & 1, i % 2);
        end

        // R11: chain 0->4->1 spliced onto list A
        link(0, 4);
        link(4, 1);
        chain = '{0, 4, 1};
        drv_rel = 1;
        step();
        drv_rel = 0;
        got.delete();
        grab(7);
        exp_s = '{0, 12, 4, 13, 1, 14, 8};
        seq_check("R11 spliced chain order");

        // R5 R6: drain both lists, keep requesting when empty
        grab(70);
        chk(n_fallback > 0, "R5 fallback exercised", n_fallback, 1);
        chk(alloc_gnt === 1'b0, "R6 no grant when drained", int'(alloc_gnt), 0);
        chk(empty0 === 1'b1 && empty1 === 1'b1, "R10 both empty", int'(empty0) + int'(empty1), 2);

        // R8: release beside grant, different then same list
        link(2, 3);
        chain = '{5};
        drv_rel = 1;
        step();
        got.delete();
        chain = '{2, 3};
        drv_req = 1;
        step();
        chain = '{8};
        step();
        drv_rel = 0;
        step();
        step();
        drv_req = 0;
        exp_s = '{5, 2, 8, 3};
        seq_check("R8 same-cycle release and grant");
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule